// File: doc/BRIEF.md
# Bridge Read Abnormal-Termination Handler

This block belongs to the target side of a bridge between PCI and an on-chip local bus. When a PCI initiator reads a local-bus slave and the local-bus side ends in an unusual way, this block chooses two responses. The first is the answer the PCI target engine gives on PCI. The second is the action the local-bus master engine takes. The protocol engines and the data FIFOs are outside the block.

The block also produces a one-cycle FIFO flush pulse, keeps three interrupt flags, and holds the address of a failing read. Each event is presented for one cycle with `evt_valid` high. That cycle carries:
- the command class, where `cmd_multi` = 0 is a plain memory read and `cmd_multi` = 1 is a read-multiple;
- the local-bus condition flags;
- the data phase index;
- an address-window overrun flag;
- the current address.

The decision is registered. It appears on the outputs for exactly the one cycle after the event.

Top module: `rd_abort_handler`

Output codes:
- `pci_resp`: 0 continue, 1 retry, 2 disconnect without data, 3 disconnect with data, 4 target abort.
- `lb_act`: 0 none, 1 let the transaction complete, 2 terminate it, 3 reissue the read.
- `irq` bits: bit 0 plain-read system error, bit 1 read-multiple system error, bit 2 local-bus slave error on a read-multiple.

## Requirements
- R1: After reset, `pci_resp`=0, `lb_act`=0, `fifo_flush`=0, `irq`=0 and `err_addr_vld`=0. In any cycle that does not follow an event, `pci_resp`, `lb_act` and `fifo_flush` are 0.
- R2: A system error on a plain read gives the following in the cycle after the event: `pci_resp`=4, `lb_act`=1, `fifo_flush`=1, and `irq` bit 0 set.
- R3: A system error on a read-multiple gives the following in the cycle after the event: `pci_resp`=4, `lb_act`=2, `fifo_flush`=1, and `irq` bit 1 set.
- R4: The parity-error flag `lb_perr` has no effect on any output for either command class.
- R5: A rearbitration request while `phase_idx`=0 gives `pci_resp`=1 and `lb_act`=0 for both command classes.
- R6: A rearbitration request with `phase_idx`≠0, or a burst-terminate, gives `pci_resp`=0 and `lb_act`=3 on a read-multiple. On a plain read it gives `pci_resp`=0 and `lb_act`=0.
- R7: A slave error on a plain read gives `pci_resp`=1 and `lb_act`=0 and sets no interrupt.
- R8: A slave error on a read-multiple gives `pci_resp`=2 and `lb_act`=0 and sets `irq` bit 2. It captures `evt_addr` into `err_addr` and sets `err_addr_vld` if no address is held.
- R9: An address-window overrun on a read-multiple gives `pci_resp`=3 and `lb_act`=0. On a plain read the overrun is ignored.
- R10: When several flags are present, the precedence is system error, then slave error, then rearbitration or burst-terminate, then address overrun.
- R11: Each `irq` bit stays set until a 1 is written to the same bit of `irq_clr`. A new set in the same cycle wins over the clear.
- R12: `err_addr` holds the first captured address until `err_addr_clr`. A clear and a new capture in the same cycle store the new address.
- R13: `fifo_flush` lasts one cycle per event, and `lb_act` is never 3 while `fifo_flush` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event present this cycle |
| cmd_multi | input | 1 | 0 plain memory read, 1 read-multiple |
| lb_serr | input | 1 | Local-bus system error |
| lb_perr | input | 1 | Local-bus parity error (ignored) |
| lb_rearb | input | 1 | Local-bus rearbitration request |
| lb_bterm | input | 1 | Local-bus slave burst-terminate |
| lb_slverr | input | 1 | Local-bus slave error or timeout |
| addr_over | input | 1 | Address beyond valid window |
| phase_idx | input | PHASE_W | Data phase index, 0 is the first phase |
| evt_addr | input | ADDR_W | Address of the current phase |
| irq_clr | input | 3 | Write-one-to-clear for `irq` |
| err_addr_clr | input | 1 | Release the held error address |
| pci_resp | output | 3 | PCI target response code |
| lb_act | output | 2 | Local-bus action code |
| fifo_flush | output | 1 | FIFO flush pulse |
| irq | output | 3 | Sticky interrupt flags |
| err_addr | output | ADDR_W | Captured error address |
| err_addr_vld | output | 1 | `err_addr` holds a capture |

## Verification
The hardest situation to reach from the ports is a slave error on a read-multiple in the same cycle as `err_addr_clr`. The held address must then be replaced rather than dropped. The stimulus reaches it in three steps. It first captures an address, then sends a second slave error that must not overwrite it. It then sends a third slave error together with the clear. Interrupt set-versus-clear collisions are produced the same way, by pulsing `irq_clr` in the cycle of a new fault on the same bit.

// File: rtl/rd_abort_pkg.sv
package rd_abort_pkg;
  typedef enum logic [2:0] {
    RSP_CONT   = 3'd0,
    RSP_RETRY  = 3'd1,
    RSP_DISC_N = 3'd2,
    RSP_DISC_D = 3'd3,
    RSP_TABORT = 3'd4
  } pci_rsp_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_CMPL  = 2'd1,
    ACT_TERM  = 2'd2,
    ACT_REISS = 2'd3
  } lb_act_e;

  localparam int unsigned IRQ_N     = 3;
  localparam int unsigned IRQ_RSERR = 0;
  localparam int unsigned IRQ_MSERR = 1;
  localparam int unsigned IRQ_SLV   = 2;

  typedef struct packed {
    pci_rsp_e           rsp;
    lb_act_e            act;
    logic               flush;
    logic [IRQ_N-1:0]   irq_set;
    logic               cap;
  } decision_t;
endpackage

// File: rtl/rd_abort_classify.sv
module rd_abort_classify
  import rd_abort_pkg::*;
(
  input  logic      multi,
  input  logic      serr,
  input  logic      slverr,
  input  logic      rearb,
  input  logic      bterm,
  input  logic      over,
  input  logic      first,
  output decision_t dec
);
  always_comb begin
    dec         = '0;
    dec.rsp     = RSP_CONT;
    dec.act     = ACT_NONE;
    if (serr) begin
      dec.rsp   = RSP_TABORT;
      dec.flush = 1'b1;
      if (multi) begin
        dec.act                = ACT_TERM;
        dec.irq_set[IRQ_MSERR] = 1'b1;
      end else begin
        dec.act                = ACT_CMPL;
        dec.irq_set[IRQ_RSERR] = 1'b1;
      end
    end else if (slverr) begin
      if (multi) begin
        dec.rsp              = RSP_DISC_N;
        dec.irq_set[IRQ_SLV] = 1'b1;
        dec.cap              = 1'b1;
      end else begin
        dec.rsp = RSP_RETRY;
      end
    end else if (rearb && first) begin
      dec.rsp = RSP_RETRY;
    end else if (rearb || bterm) begin
      if (multi) dec.act = ACT_REISS;
    end else if (over && multi) begin
      dec.rsp = RSP_DISC_D;
    end
  end
endmodule

// File: rtl/rd_abort_irq.sv
module rd_abort_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q, d, en;
    always_comb begin
      en = set[i] | clr[i];
      d  = set[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end
    assign flag[i] = q;

    assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr[i]) |=> q);
  end
endmodule

// File: rtl/rd_abort_addr.sv
module rd_abort_addr #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              vld_q
);
  logic load, vld_d, vld_en;

  always_comb begin
    load   = cap & (~vld_q | clr);
    vld_en = load | clr;
    vld_d  = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= 1'b0;
    else if (vld_en) vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= addr_in;
  end

  assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !clr) |=> (vld_q && $stable(addr_q)));
endmodule

// File: rtl/rd_abort_handler.sv
module rd_abort_handler
  import rd_abort_pkg::*;
#(
  parameter int unsigned PHASE_W = 8,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  input  logic               cmd_multi,
  input  logic               lb_serr,
  input  logic               lb_perr,
  input  logic               lb_rearb,
  input  logic               lb_bterm,
  input  logic               lb_slverr,
  input  logic               addr_over,
  input  logic [PHASE_W-1:0] phase_idx,
  input  logic [ADDR_W-1:0]  evt_addr,
  input  logic [2:0]         irq_clr,
  input  logic               err_addr_clr,
  output logic [2:0]         pci_resp,
  output logic [1:0]         lb_act,
  output logic               fifo_flush,
  output logic [2:0]         irq,
  output logic [ADDR_W-1:0]  err_addr,
  output logic               err_addr_vld
);
  decision_t dec, dec_g, out_q;
  logic      first_ph;

  assign first_ph = (phase_idx == '0);

  rd_abort_classify u_cls (
    .multi (cmd_multi),
    .serr  (lb_serr),
    .slverr(lb_slverr),
    .rearb (lb_rearb),
    .bterm (lb_bterm),
    .over  (addr_over),
    .first (first_ph),
    .dec   (dec)
  );

  always_comb begin
    dec_g = evt_valid ? dec : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= dec_g;
  end

  assign pci_resp   = out_q.rsp;
  assign lb_act     = out_q.act;
  assign fifo_flush = out_q.flush;

  rd_abort_irq #(.N(IRQ_N)) u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (dec_g.irq_set),
    .clr  (irq_clr),
    .flag (irq)
  );

  rd_abort_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (dec_g.cap),
    .clr    (err_addr_clr),
    .addr_in(evt_addr),
    .addr_q (err_addr),
    .vld_q  (err_addr_vld)
  );

  assert_flush_no_reissue_R13: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (lb_act != ACT_REISS));
  assert_flush_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(evt_valid)) |-> (!fifo_flush && pci_resp == RSP_CONT && lb_act == ACT_NONE));
  assert_flush_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (pci_resp == RSP_TABORT && $past(lb_serr)));
  assert_reissue_multi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_act == ACT_REISS) |-> ($past(cmd_multi) && $past(phase_idx) != '0 || $past(cmd_multi) && $past(lb_bterm)));
  assert_disc_data_multi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_resp == RSP_DISC_D) |-> ($past(cmd_multi) && $past(addr_over)));
  assert_perr_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && lb_perr && !lb_serr && !lb_slverr && !lb_rearb && !lb_bterm && !addr_over)
      |=> (pci_resp == RSP_CONT && lb_act == ACT_NONE && !fifo_flush));
  assert_serr_multi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && lb_serr && cmd_multi) |=> (lb_act == ACT_TERM && irq[IRQ_MSERR]));
endmodule

// File: tb/rd_abort_handler_tb_top.sv
module rd_abort_handler_tb_top;
  localparam int PW = 8;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic evt_valid, cmd_multi, lb_serr, lb_perr, lb_rearb, lb_bterm, lb_slverr, addr_over;
  logic [PW-1:0] phase_idx;
  logic [AW-1:0] evt_addr;
  logic [2:0]    irq_clr;
  logic          err_addr_clr;
  logic [2:0]    pci_resp;
  logic [1:0]    lb_act;
  logic          fifo_flush;
  logic [2:0]    irq;
  logic [AW-1:0] err_addr;
  logic          err_addr_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          m_resp, m_act;
  bit          m_flush, m_av;
  bit [2:0]    m_irq;
  bit [AW-1:0] m_addr;

  always #4 clk = ~clk;

  rd_abort_handler #(.PHASE_W(PW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .cmd_multi(cmd_multi),
    .lb_serr(lb_serr), .lb_perr(lb_perr), .lb_rearb(lb_rearb), .lb_bterm(lb_bterm),
    .lb_slverr(lb_slverr), .addr_over(addr_over), .phase_idx(phase_idx),
    .evt_addr(evt_addr), .irq_clr(irq_clr), .err_addr_clr(err_addr_clr),
    .pci_resp(pci_resp), .lb_act(lb_act), .fifo_flush(fifo_flush), .irq(irq),
    .err_addr(err_addr), .err_addr_vld(err_addr_vld)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "pci_resp", int'(pci_resp), m_resp);
    chk(tag, "lb_act", int'(lb_act), m_act);
    chk(tag, "fifo_flush", int'(fifo_flush), int'(m_flush));
    chk(tag, "irq", int'(irq), int'(m_irq));
    chk(tag, "err_addr_vld", int'(err_addr_vld), int'(m_av));
    if (m_av) chk(tag, "err_addr", int'(err_addr), int'(m_addr));
  endtask

  // One cycle: drive at negedge, model the next state, compare at the next negedge.
  task automatic step(input bit ev, input bit mu, input bit se, input bit pe,
                      input bit ra, input bit bt, input bit sl, input bit ov,
                      input int ph, input bit [AW-1:0] ad, input bit [2:0] ic,
                      input bit ac, input string tag);
    bit [2:0] set;
    bit cap;
    evt_valid = ev; cmd_multi = mu; lb_serr = se; lb_perr = pe; lb_rearb = ra;
    lb_bterm = bt; lb_slverr = sl; addr_over = ov; phase_idx = PW'(ph);
    evt_addr = ad; irq_clr = ic; err_addr_clr = ac;
    set = 3'b000; cap = 0;
    m_resp = 0; m_act = 0; m_flush = 0;
    if (ev) begin
      case (1'b1)
        se: begin
          m_resp = 4; m_flush = 1;
          m_act = mu ? 2 : 1;
          if (mu) set[1] = 1; else set[0] = 1;
        end
        sl: begin
          m_resp = mu ? 2 : 1;
          if (mu) begin set[2] = 1; cap = 1; end
        end
        (ra && ph == 0): m_resp = 1;
        (ra || bt): m_act = mu ? 3 : 0;
        (ov && mu): m_resp = 3;
        default: ;
      endcase
    end
    @(posedge clk);
    m_irq = (m_irq & ~ic) | set;
    if (cap && (!m_av || ac)) begin m_av = 1; m_addr = ad; end
    else if (ac) m_av = 0;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(0,0,0,0,0,0,0,0,0,'0,3'b000,0,tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    evt_valid = 0; cmd_multi = 0; lb_serr = 0; lb_perr = 0; lb_rearb = 0;
    lb_bterm = 0; lb_slverr = 0; addr_over = 0; phase_idx = '0; evt_addr = '0;
    irq_clr = 0; err_addr_clr = 0;
    m_resp = 0; m_act = 0; m_flush = 0; m_av = 0; m_irq = 0; m_addr = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    idle("R1");

    // R4: parity only, both classes, several phases
    step(1,0,0,1,0,0,0,0,0,32'h10,0,0,"R4");
    step(1,1,0,1,0,0,0,0,5,32'h14,0,0,"R4");
    // R5: rearbitration on the first phase
    step(1,0,0,0,1,0,0,0,0,32'h20,0,0,"R5");
    step(1,1,0,0,1,0,0,0,0,32'h24,0,0,"R5");
    // R6: later rearbitration and burst-terminate
    step(1,1,0,0,1,0,0,0,3,32'h28,0,0,"R6");
    step(1,1,0,0,0,1,0,0,0,32'h2C,0,0,"R6");
    step(1,0,0,0,1,0,0,0,3,32'h30,0,0,"R6");
    step(1,0,0,0,0,1,0,0,7,32'h34,0,0,"R6");
    // R9: address window overrun
    step(1,1,0,0,0,0,0,1,9,32'h40,0,0,"R9");
    step(1,0,0,0,0,0,0,1,9,32'h44,0,0,"R9");
    // R7: slave error on plain read
    step(1,0,0,0,0,0,1,0,2,32'h50,0,0,"R7");
    // R8 / R12: slave error on read-multiple, first capture then hold
    step(1,1,0,0,0,0,1,0,2,32'hA000_0100,0,0,"R8");
    idle("R13");
    step(1,1,0,0,0,0,1,0,4,32'hA000_0200,0,0,"R12");
    step(1,1,0,0,0,0,1,0,4,32'hA000_0300,0,1,"R12");
    step(0,0,0,0,0,0,0,0,0,'0,0,1,"R12");
    idle("R12");
    // R2 / R3: system errors
    step(1,0,1,0,0,0,0,0,1,32'h60,0,0,"R2");
    idle("R13");
    step(1,1,1,0,0,0,0,0,1,32'h64,0,0,"R3");
    idle("R13");
    // R10: precedence
    step(1,1,1,1,1,1,1,1,2,32'h70,0,0,"R10");
    step(1,1,0,0,1,1,1,1,2,32'hB000_0000,0,1,"R10");
    step(1,1,0,0,1,0,0,1,0,32'h74,0,0,"R10");
    step(1,1,0,0,0,1,0,1,6,32'h78,0,0,"R10");
    // R11: clear, set-wins collision
    step(0,0,0,0,0,0,0,0,0,'0,3'b001,0,"R11");
    step(1,1,1,0,0,0,0,0,1,32'h80,3'b010,0,"R11");
    step(0,0,0,0,0,0,0,0,0,'0,3'b110,0,"R11");
    idle("R11");
    // R13: back-to-back system errors, flush per event
    step(1,0,1,0,0,0,0,0,0,32'h90,0,0,"R13");
    step(1,1,1,0,1,1,0,0,4,32'h94,0,0,"R13");
    idle("R13");
    for (int i = 0; i < 16; i++) begin
      step(1, i[0], 0, i[1], i[2], i[3], 0, 1, i, 32'hC00 + i, 3'b111, 1, "R6");
    end
    idle("R1");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule